// File: doc/BRIEF.md
# Retired-Op Sampling Unit

This unit picks one micro-operation out of the execution pipeline at a programmable interval and follows it until it leaves the machine. A period counter is loaded from the `period` input. It counts down either on every clock (cycle selection) or on every dispatched op (dispatch selection). The op that is dispatched in the cycle the counter sits at zero becomes the tagged op, and the unit remembers its identifier and the address of its parent instruction.

While the op is tagged, event strobes that carry its identifier are collected into a flag word. These events cover branch outcome, return outcome, load, store, data-cache miss and off-core request. When the tagged op retires, the unit latches a record and raises a one-cycle interrupt. The record holds the address, the flags and a cycle timestamp. The record and its valid bit stay put until software clears them.

In cycle selection, the counter can expire in a cycle with no dispatch. The unit then gives up that chance and restarts from a small pseudo-random count. A flush of the tagged op cancels the sample in the same way.

Top module: `op_sample_unit`

## Requirements
- R1: During and after a synchronous reset (`rst` high at a clock edge), `smp_valid`, `smp_irq`, `smp_addr`, `smp_flags` and `smp_time` are all zero.
- R2: With `mode_dispatch`=0, counting starts with the count equal to `period`, and the count falls by one on every clock. The op dispatched in the clock where the count is zero is tagged. So when `enable` rises from idle, the op dispatched in the (`period`+1)-th counting clock is the one tagged.
- R3: With `mode_dispatch`=1, the count falls by one on each dispatch. The dispatch that arrives while the count is zero is tagged, so the (`period`+1)-th dispatch after counting starts is the one tagged.
- R4: In cycle selection, if the count is zero in a clock with no dispatch, nothing is tagged. The count reloads from the low 4 bits of a 16-bit LFSR, so it is at most 15. The LFSR resets to 16'hACE1 and shifts left every clock, taking in bit15^bit13^bit12^bit10.
- R5: A retire strobe whose `ret_id` matches the tagged op has the following effect one clock later: `smp_valid`=1, `smp_irq` pulses high for exactly one clock, `smp_addr` holds the `disp_addr` of the tagged dispatch, and `smp_time` holds the timestamp of the retire clock. The timestamp is 0 in the first clock after reset and rises by one every clock.
- R6: `smp_flags` is the OR of the `evt_flags` of every event strobe whose `evt_id` matches the tagged op. This includes events from the clock after tagging up to and including the retire clock. Events with other identifiers are ignored. Bit meanings: 0 branch, 1 branch mispredicted, 2 return, 3 return mispredicted, 4 load, 5 store, 6 data-cache miss, 7 off-core request.
- R7: A flush strobe that matches the tagged op cancels the sample, and no record appears. Counting resumes from the low 4 bits of the LFSR. If a retire and a flush of the tagged op fall in the same clock, the retire wins.
- R8: While `smp_valid` is 1, no op is tagged, and dispatch, retire and event strobes leave the record and `smp_irq` unchanged.
- R9: `sample_clear` while `smp_valid` is 1 makes `smp_valid` 0 one clock later. Counting then restarts from `period`.
- R10: `enable` low in the counting or tracking phase abandons any tagged op, so a later retire of it yields no record. Counting restarts from `period` when `enable` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Sampling on |
| mode_dispatch | input | 1 | 1: count dispatches, 0: count clocks |
| period | input | CNT_W | Sampling interval |
| disp_valid | input | 1 | An op is dispatched this clock |
| disp_id | input | ID_W | Identifier of the dispatched op |
| disp_addr | input | ADDR_W | Parent instruction address of the dispatched op |
| ret_valid | input | 1 | An op retires this clock |
| ret_id | input | ID_W | Identifier of the retiring op |
| flush_valid | input | 1 | An op is flushed this clock |
| flush_id | input | ID_W | Identifier of the flushed op |
| evt_valid | input | 1 | Event strobe |
| evt_id | input | ID_W | Identifier of the op the event belongs to |
| evt_flags | input | NFLAG | Event bits, positions as in R6 |
| sample_clear | input | 1 | Software acknowledge of the record |
| smp_valid | output | 1 | Record valid |
| smp_irq | output | 1 | One-clock interrupt pulse |
| smp_addr | output | ADDR_W | Recorded instruction address |
| smp_flags | output | NFLAG | Recorded event flags |
| smp_time | output | TIME_W | Recorded timestamp |

## Verification
An event strobe for the tagged op and its retire can fall in the same clock. The flags carried in that clock must still reach the record. The directed sequence sends a store event together with the retire, and expects the branch bit seen earlier ORed with the store bit. The random phase also collides retires with flushes and events on the same small set of identifiers, and a cycle-level reference model in the bench judges each collision (retire over flush, event merged into the record).

// File: rtl/osu_pkg.sv
package osu_pkg;
  localparam int NFLAG = 8;
  localparam int FLG_BR       = 0;
  localparam int FLG_BR_MISS  = 1;
  localparam int FLG_RT       = 2;
  localparam int FLG_RT_MISS  = 3;
  localparam int FLG_LD       = 4;
  localparam int FLG_ST       = 5;
  localparam int FLG_DC_MISS  = 6;
  localparam int FLG_OFFCORE  = 7;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_COUNT = 2'd1,
    S_TRACK = 2'd2,
    S_HOLD  = 2'd3
  } osu_state_e;
endpackage

// File: rtl/osu_lfsr.sv
module osu_lfsr #(
  parameter int          LFSR_W = 16,
  parameter int          RAND_W = 4,
  parameter logic [15:0] SEED   = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  output logic [RAND_W-1:0] rnd
);
  logic [LFSR_W-1:0] st_q;
  logic              fb;

  assign fb  = st_q[LFSR_W-1] ^ st_q[LFSR_W-3] ^ st_q[LFSR_W-4] ^ st_q[LFSR_W-6];
  assign rnd = st_q[RAND_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) st_q <= SEED[LFSR_W-1:0];
    else     st_q <= {st_q[LFSR_W-2:0], fb};
  end

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst) st_q != '0); // R4
endmodule

// File: rtl/osu_period_ctr.sv
module osu_period_ctr #(
  parameter int CNT_W  = 8,
  parameter int RAND_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_period,
  input  logic [CNT_W-1:0]  period,
  input  logic              load_rand,
  input  logic [RAND_W-1:0] rand_val,
  input  logic              dec,
  output logic              rem_zero
);
  localparam logic [CNT_W-1:0] RAND_MAX = CNT_W'((1 << RAND_W) - 1);

  logic [CNT_W-1:0] rem_q;

  assign rem_zero = (rem_q == '0);

  always_ff @(posedge clk) begin
    if (rst)              rem_q <= '0;
    else if (load_period) rem_q <= period;
    else if (load_rand)   rem_q <= {{(CNT_W-RAND_W){1'b0}}, rand_val};
    else if (dec && !rem_zero) rem_q <= rem_q - 1'b1;
  end

  AST_RAND_SMALL: assert property (@(posedge clk) disable iff (rst)
    (load_rand && !load_period) |=> (rem_q <= RAND_MAX)); // R4
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (dec && !load_period && !load_rand && !rem_zero) |=> (rem_q == $past(rem_q) - 1'b1)); // R2
endmodule

// File: rtl/osu_tag_track.sv
module osu_tag_track #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int NFLAG  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tag_now,
  input  logic [ID_W-1:0]   disp_id,
  input  logic [ADDR_W-1:0] disp_addr,
  input  logic              tracking,
  input  logic              evt_valid,
  input  logic [ID_W-1:0]   evt_id,
  input  logic [NFLAG-1:0]  evt_flags,
  input  logic              ret_valid,
  input  logic [ID_W-1:0]   ret_id,
  input  logic              flush_valid,
  input  logic [ID_W-1:0]   flush_id,
  output logic              ret_hit,
  output logic              flush_hit,
  output logic [ADDR_W-1:0] tag_addr,
  output logic [NFLAG-1:0]  flags_now
);
  logic [ID_W-1:0]  tag_id_q;
  logic [NFLAG-1:0] flags_q;
  logic             evt_hit;

  assign evt_hit   = tracking && evt_valid && (evt_id == tag_id_q);
  assign ret_hit   = tracking && ret_valid && (ret_id == tag_id_q);
  assign flush_hit = tracking && !ret_hit && flush_valid && (flush_id == tag_id_q);
  assign flags_now = flags_q | (evt_hit ? evt_flags : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_id_q <= '0;
      tag_addr <= '0;
      flags_q  <= '0;
    end else if (tag_now) begin
      tag_id_q <= disp_id;
      tag_addr <= disp_addr;
      flags_q  <= '0;
    end else if (evt_hit) begin
      flags_q  <= flags_now;
    end
  end

  AST_FLAGS_GROW: assert property (@(posedge clk) disable iff (rst)
    tracking |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R6
endmodule

// File: rtl/op_sample_unit.sv
module op_sample_unit
  import osu_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8,
  parameter int TIME_W = 32,
  parameter int LFSR_W = 16,
  parameter int RAND_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              mode_dispatch,
  input  logic [CNT_W-1:0]  period,
  input  logic              disp_valid,
  input  logic [ID_W-1:0]   disp_id,
  input  logic [ADDR_W-1:0] disp_addr,
  input  logic              ret_valid,
  input  logic [ID_W-1:0]   ret_id,
  input  logic              flush_valid,
  input  logic [ID_W-1:0]   flush_id,
  input  logic              evt_valid,
  input  logic [ID_W-1:0]   evt_id,
  input  logic [NFLAG-1:0]  evt_flags,
  input  logic              sample_clear,
  output logic              smp_valid,
  output logic              smp_irq,
  output logic [ADDR_W-1:0] smp_addr,
  output logic [NFLAG-1:0]  smp_flags,
  output logic [TIME_W-1:0] smp_time
);
  osu_state_e        st_q, st_d;
  logic [TIME_W-1:0] ts_q;
  logic [RAND_W-1:0] rnd;
  logic              rem_zero, cnt_tick, expire, tag_now, skip_now;
  logic              ret_hit, flush_raw, flush_hit, load_period, load_rand;
  logic              in_count, in_track;
  logic [ADDR_W-1:0] tag_addr;
  logic [NFLAG-1:0]  flags_now;

  assign in_count    = (st_q == S_COUNT);
  assign in_track    = (st_q == S_TRACK);
  assign cnt_tick    = in_count && enable && (mode_dispatch ? disp_valid : 1'b1);
  assign expire      = cnt_tick && rem_zero;
  assign tag_now     = expire && disp_valid;
  assign skip_now    = expire && !disp_valid;
  assign flush_hit   = flush_raw && enable;
  assign load_period = (st_q == S_IDLE) || (st_q == S_HOLD) ||
                       (in_count && !enable) || (in_track && !ret_hit && !enable);
  assign load_rand   = skip_now || flush_hit;

  osu_lfsr #(.LFSR_W(LFSR_W), .RAND_W(RAND_W)) u_lfsr (
    .clk(clk), .rst(rst), .rnd(rnd)
  );

  osu_period_ctr #(.CNT_W(CNT_W), .RAND_W(RAND_W)) u_ctr (
    .clk(clk), .rst(rst), .load_period(load_period), .period(period),
    .load_rand(load_rand), .rand_val(rnd), .dec(cnt_tick), .rem_zero(rem_zero)
  );

  osu_tag_track #(.ID_W(ID_W), .ADDR_W(ADDR_W), .NFLAG(NFLAG)) u_trk (
    .clk(clk), .rst(rst), .tag_now(tag_now), .disp_id(disp_id),
    .disp_addr(disp_addr), .tracking(in_track), .evt_valid(evt_valid),
    .evt_id(evt_id), .evt_flags(evt_flags), .ret_valid(ret_valid),
    .ret_id(ret_id), .flush_valid(flush_valid), .flush_id(flush_id),
    .ret_hit(ret_hit), .flush_hit(flush_raw), .tag_addr(tag_addr),
    .flags_now(flags_now)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (enable) st_d = S_COUNT;
      S_COUNT: if (!enable) st_d = S_IDLE;
               else if (tag_now) st_d = S_TRACK;
      S_TRACK: if (ret_hit) st_d = S_HOLD;
               else if (!enable) st_d = S_IDLE;
               else if (flush_hit) st_d = S_COUNT;
      S_HOLD:  if (sample_clear) st_d = enable ? S_COUNT : S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      ts_q      <= '0;
      smp_valid <= 1'b0;
      smp_irq   <= 1'b0;
      smp_addr  <= '0;
      smp_flags <= '0;
      smp_time  <= '0;
    end else begin
      st_q    <= st_d;
      ts_q    <= ts_q + 1'b1;
      smp_irq <= ret_hit;
      if (ret_hit) begin
        smp_valid <= 1'b1;
        smp_addr  <= tag_addr;
        smp_flags <= flags_now;
        smp_time  <= ts_q;
      end else if ((st_q == S_HOLD) && sample_clear) begin
        smp_valid <= 1'b0;
      end
    end
  end

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst) smp_irq |=> !smp_irq); // R5
  AST_IRQ_WITH_VALID: assert property (@(posedge clk) disable iff (rst) smp_irq |-> smp_valid); // R5
  AST_NO_TAG_HELD: assert property (@(posedge clk) disable iff (rst) smp_valid |-> !tag_now); // R8
  AST_RECORD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !sample_clear) |=> (smp_valid && $stable(smp_addr) && $stable(smp_flags) && $stable(smp_time))); // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && sample_clear) |=> !smp_valid); // R9
endmodule

// File: tb/sim_op_sample_unit.sv
`timescale 1ns/1ps
module sim_op_sample_unit;
  localparam int ID_W = 4, ADDR_W = 32, CNT_W = 8, TIME_W = 32, NF = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic enable, mode_dispatch, disp_valid, ret_valid, flush_valid, evt_valid, sample_clear;
  logic [CNT_W-1:0] period;
  logic [ID_W-1:0] disp_id, ret_id, flush_id, evt_id;
  logic [ADDR_W-1:0] disp_addr;
  logic [NF-1:0] evt_flags;
  logic smp_valid, smp_irq;
  logic [ADDR_W-1:0] smp_addr;
  logic [NF-1:0] smp_flags;
  logic [TIME_W-1:0] smp_time;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic model_on = 1'b0;

  always #2 clk = ~clk;

  op_sample_unit u0 (
    .clk(clk), .rst(rst), .enable(enable), .mode_dispatch(mode_dispatch), .period(period),
    .disp_valid(disp_valid), .disp_id(disp_id), .disp_addr(disp_addr),
    .ret_valid(ret_valid), .ret_id(ret_id), .flush_valid(flush_valid), .flush_id(flush_id),
    .evt_valid(evt_valid), .evt_id(evt_id), .evt_flags(evt_flags), .sample_clear(sample_clear),
    .smp_valid(smp_valid), .smp_irq(smp_irq), .smp_addr(smp_addr), .smp_flags(smp_flags),
    .smp_time(smp_time)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr_next(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [NF-1:0] merge_flags(logic [NF-1:0] acc, logic hit, logic [NF-1:0] f);
    return hit ? (acc | f) : acc;
  endfunction

  // reference model, states: 0 idle, 1 counting, 2 tracking, 3 holding
  int m_st;
  logic [CNT_W-1:0] m_rem;
  logic [15:0] m_lfsr;
  logic [TIME_W-1:0] m_ts, m_time;
  logic [ID_W-1:0] m_tag;
  logic [ADDR_W-1:0] m_taddr, m_addr;
  logic [NF-1:0] m_tfl, m_flags;
  logic m_valid, m_irq;

  always @(posedge clk) begin
    logic tick, expire, tagn, skip, hret, hfl, evh, ldp;
    logic [NF-1:0] nfl;
    if (rst) begin
      m_st <= 0; m_rem <= '0; m_lfsr <= 16'hACE1; m_ts <= '0; m_tag <= '0;
      m_taddr <= '0; m_tfl <= '0; m_valid <= 1'b0; m_irq <= 1'b0;
      m_addr <= '0; m_flags <= '0; m_time <= '0;
    end else begin
      tick   = (m_st == 1) && enable && (mode_dispatch ? disp_valid : 1'b1);
      expire = tick && (m_rem == 0);
      tagn   = expire && disp_valid;
      skip   = expire && !disp_valid;
      hret   = (m_st == 2) && ret_valid && (ret_id == m_tag);
      hfl    = (m_st == 2) && !hret && enable && flush_valid && (flush_id == m_tag);
      evh    = (m_st == 2) && evt_valid && (evt_id == m_tag);
      nfl    = merge_flags(m_tfl, evh, evt_flags);
      ldp    = (m_st == 0) || (m_st == 3) || ((m_st == 1) && !enable) ||
               ((m_st == 2) && !hret && !enable);
      if (ldp) m_rem <= period;
      else if (skip || hfl) m_rem <= {4'd0, m_lfsr[3:0]};
      else if (tick && m_rem != 0) m_rem <= m_rem - 1'b1;
      case (m_st)
        0: if (enable) m_st <= 1;
        1: if (!enable) m_st <= 0; else if (tagn) m_st <= 2;
        2: if (hret) m_st <= 3; else if (!enable) m_st <= 0; else if (hfl) m_st <= 1;
        default: if (sample_clear) m_st <= enable ? 1 : 0;
      endcase
      if (tagn) begin m_tag <= disp_id; m_taddr <= disp_addr; m_tfl <= '0; end
      else if (evh) m_tfl <= nfl;
      m_irq <= hret;
      if (hret) begin m_valid <= 1'b1; m_addr <= m_taddr; m_flags <= nfl; m_time <= m_ts; end
      else if ((m_st == 3) && sample_clear) m_valid <= 1'b0;
      m_ts <= m_ts + 1'b1;
      m_lfsr <= lfsr_next(m_lfsr);
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (model_on && !rst) begin
      chk("R5/R8/R9 valid", smp_valid, m_valid);
      chk("R5 irq", smp_irq, m_irq);
      if (m_valid) begin
        chk("R2/R3 addr", smp_addr, m_addr);
        chk("R6 flags", smp_flags, m_flags);
        chk("R5 time", smp_time, m_time);
      end
    end
    if (cyc > 60000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected < 60000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic quiet();
    disp_valid = 0; ret_valid = 0; flush_valid = 0; evt_valid = 0; sample_clear = 0;
    disp_id = '0; ret_id = '0; flush_id = '0; evt_id = '0; disp_addr = '0; evt_flags = '0;
  endtask

  task automatic tick_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int seen;
    void'($urandom(32'd1234));
    quiet(); enable = 0; mode_dispatch = 0; period = '0;
    tick_n(3);
    chk("R1 valid", smp_valid, 0); chk("R1 irq", smp_irq, 0);
    chk("R1 addr", smp_addr, 0); chk("R1 flags", smp_flags, 0); chk("R1 time", smp_time, 0);
    rst = 0; model_on = 1;

    // R3 dispatch selection, R6 flag merge incl. retire-cycle event
    enable = 1; mode_dispatch = 1; period = 2;
    tick_n(1);
    disp_valid = 1; disp_id = 1; disp_addr = 32'hA1; tick_n(1);
    disp_id = 2; disp_addr = 32'hA2; tick_n(1);
    disp_id = 3; disp_addr = 32'hA3; tick_n(1);
    quiet(); evt_valid = 1; evt_id = 3; evt_flags = 8'h01; tick_n(1);
    evt_id = 1; evt_flags = 8'h10; tick_n(1);
    evt_id = 3; evt_flags = 8'h20; ret_valid = 1; ret_id = 3; tick_n(1);
    quiet();
    chk("R5 valid after retire", smp_valid, 1); chk("R5 irq pulse", smp_irq, 1);
    chk("R3 third dispatch tagged", smp_addr, 32'hA3);
    chk("R6 branch|store merged", smp_flags, 8'h21);
    tick_n(1);
    chk("R5 irq one clock", smp_irq, 0);

    // R8 held record ignores traffic
    disp_valid = 1; disp_id = 3; disp_addr = 32'hBB; ret_valid = 1; ret_id = 3;
    evt_valid = 1; evt_id = 3; evt_flags = 8'hC0;
    tick_n(4); quiet(); tick_n(1);
    chk("R8 valid held", smp_valid, 1); chk("R8 addr held", smp_addr, 32'hA3);
    chk("R8 flags held", smp_flags, 8'h21); chk("R8 no irq", smp_irq, 0);

    // R9 clear
    sample_clear = 1; tick_n(1); quiet();
    chk("R9 cleared", smp_valid, 0);

    // R7 flush cancels, then re-arm
    repeat (3) begin disp_valid = 1; disp_id = 5; disp_addr = 32'hA5; tick_n(1); end
    quiet(); flush_valid = 1; flush_id = 5; tick_n(1);
    quiet(); ret_valid = 1; ret_id = 5; tick_n(1); quiet(); tick_n(1);
    chk("R7 no record after flush", smp_valid, 0);
    disp_valid = 1; disp_id = 5; disp_addr = 32'hA6; tick_n(17);
    quiet(); ret_valid = 1; ret_id = 5; tick_n(1); quiet();
    chk("R7 re-armed sample", smp_valid, 1); chk("R7 re-armed addr", smp_addr, 32'hA6);
    period = 0; sample_clear = 1; tick_n(1); quiet();

    // R10 disable abandons tag
    disp_valid = 1; disp_id = 6; disp_addr = 32'hA7; tick_n(1);
    quiet(); enable = 0; tick_n(1);
    enable = 1; ret_valid = 1; ret_id = 6; tick_n(1); quiet(); tick_n(1);
    chk("R10 abandoned", smp_valid, 0);

    // R4 skip in cycle selection, restart small
    mode_dispatch = 0; period = 20; tick_n(30);
    seen = 0;
    for (int i = 0; i < 19; i++) begin
      disp_valid = 1; disp_id = 7; disp_addr = 32'hA8; ret_valid = 1; ret_id = 7;
      tick_n(1);
      if (smp_valid) seen = 1;
    end
    quiet();
    chk("R4 tagged within small restart", seen, 1);
    chk("R4 addr", smp_addr, 32'hA8);
    sample_clear = 1; tick_n(1); quiet();

    // R2 exact cycle count from idle
    enable = 0; period = 3; tick_n(1);
    enable = 1;
    for (int k = 0; k < 8; k++) begin
      disp_valid = 1; disp_id = 4'(k); disp_addr = 32'h100 + k; ret_valid = 1; ret_id = 4;
      tick_n(1);
    end
    quiet(); tick_n(1);
    chk("R2 fifth dispatch tagged", smp_addr, 32'h104);
    chk("R2 valid", smp_valid, 1);
    sample_clear = 1; tick_n(1); quiet();

    // random mix, judged by the model
    for (int i = 0; i < 9000; i++) begin
      if (i % 1500 == 0) begin mode_dispatch = 1'($urandom % 2); period = CNT_W'($urandom % 10); end
      enable       = ($urandom % 64) != 0;
      disp_valid   = ($urandom % 3) != 0; disp_id = ID_W'($urandom % 4); disp_addr = $urandom;
      ret_valid    = ($urandom % 2) != 0; ret_id = ID_W'($urandom % 4);
      flush_valid  = ($urandom % 8) == 0; flush_id = ID_W'($urandom % 4);
      evt_valid    = ($urandom % 2) != 0; evt_id = ID_W'($urandom % 4); evt_flags = NF'($urandom);
      sample_clear = ($urandom % 8) == 0;
      tick_n(1);
    end
    quiet(); tick_n(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule